// File: doc/BRIEF.md
# Multi-lane Serial Transfer Engine

This block moves a programmed number of bytes across a half-duplex serial link using one, two or four data lanes at single data rate. Each transfer is configured by a direction bit, a lane-mode code, a fragment flag and a chip-select number, then started by writing a byte count. In a write transfer, bytes are pulled from a transmit FIFO through a ready/valid handshake and shifted out. In a read transfer, incoming bits are gathered into bytes and offered to a receive FIFO through a second ready/valid handshake.

The engine runs on a core clock four times faster than the serial clock it produces. Every bit slot therefore lasts four core cycles. The serial clock idles low. Data changes on its falling edge and is captured on its rising edge. When the count runs out, the engine emits a one-cycle completion pulse. Depending on the fragment flag, it either releases chip-select or keeps it asserted so that the next transfer continues the same frame.

Top module: `qspi_pio_engine`

## Requirements
- R1: A transfer starts only when `start_wr` is high in idle with a nonzero `start_count`. A zero count, or a start while a transfer is running, has no effect.
- R2: A write (`cfg_dir`=0) enables the active lanes' output enables for the whole transfer. A read (`cfg_dir`=1) keeps every output enable low and delivers each received byte on `rx_data` with `rx_valid`.
- R3: The lane code is 1 for single, 2 for dual and 4 for quad; every other code acts as single. Bytes travel MSB first.
  - Single: writes use lane 0 and reads use lane 1.
  - Dual: lanes 1..0 carry each bit pair, with the higher bit on lane 1.
  - Quad: lanes 3..0 carry each nibble, upper nibble first.
- R4: With `cfg_frag`=1, chip-select is deasserted in the cycle `done` is high. With `cfg_frag`=0, it stays asserted after `done`.
- R5: `cfg_cs_sel`=0 drives `cs_n[0]` low and `cfg_cs_sel`=1 drives `cs_n[1]` low. At most one chip-select is ever low.
- R6: `sclk` idles low. Each bit slot spans four core cycles: two with `sclk` low, then two with `sclk` high. Consecutive rising edges within a byte are exactly four cycles apart.
- R7: In a write, while the transmit FIFO has no byte ready, `sclk` stays low and no bit slot advances.
- R8: `done` is high for exactly one cycle after the last bit slot. All lane output enables are low in that cycle.
- R9: In a read, a byte held on `rx_valid` without `rx_ready` stalls the engine with `sclk` low until it is accepted. No received byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four times the serial clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dir | input | 1 | 0 write, 1 read; latched at start |
| cfg_lanes | input | 3 | Lane-mode code (1, 2, 4; others single) |
| cfg_frag | input | 1 | 1 releases chip-select at end of transfer |
| cfg_cs_sel | input | 1 | Chip-select line choice |
| start_wr | input | 1 | Strobe that writes `start_count` |
| start_count | input | 16 | Number of bytes to transfer |
| tx_data | input | 8 | Transmit FIFO byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes the transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Receive FIFO accepts the byte |
| sclk | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip-selects |
| lane_out | output | 4 | Lane output data |
| lane_oe | output | 4 | Lane output enables |
| lane_in | input | 4 | Lane input data |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
On the final byte of a read, the completion pulse and the handoff of that last byte to the receive side fall in the same core cycle. Because of this, a consumer can see `done` while one byte is still pending. The bench runs reads in several lane modes, keeps `rx_ready` high at the end, and checks that `rx_valid` is high in the very cycle `done` is. It then confirms that the pending byte is still collected and matches the driven pattern. A second overlap is a start strobe landing while the engine is mid-transfer. The bench pulses it during a quad write and judges it by the absence of any further `tx_ready` after completion.

// File: rtl/qspi_pio_engine.sv
module qspi_pio_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dir,
  input  logic [2:0]       cfg_lanes,
  input  logic             cfg_frag,
  input  logic             cfg_cs_sel,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_count,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sclk,
  output logic [1:0]       cs_n,
  output logic [3:0]       lane_out,
  output logic [3:0]       lane_oe,
  input  logic [3:0]       lane_in,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SHIFT} state_t;

  state_t           st;
  logic             dir_q, frag_q, cs_sel_q, cs_on;
  logic [2:0]       w_q;
  logic [CNT_W-1:0] left;
  logic [7:0]       sh, rx_q;
  logic [3:0]       slots;
  logic [1:0]       ph;
  logic             rx_v, done_q;

  wire [2:0] w_dec = (cfg_lanes == 3'd4) ? 3'd4 :
                     (cfg_lanes == 3'd2) ? 3'd2 : 3'd1;
  wire quad = (w_q == 3'd4);
  wire dual = (w_q == 3'd2);
  wire [3:0] slots_init = quad ? 4'd2 : dual ? 4'd4 : 4'd8;
  wire start_ok = (st == S_IDLE) && start_wr && (start_count != '0);

  wire [7:0] sh_in  = quad ? {sh[3:0], lane_in} :
                      dual ? {sh[5:0], lane_in[1:0]} : {sh[6:0], lane_in[1]};
  wire [7:0] sh_out = quad ? {sh[3:0], 4'b0} :
                      dual ? {sh[5:0], 2'b0} : {sh[6:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dir_q    <= 1'b0;
      frag_q   <= 1'b0;
      cs_sel_q <= 1'b0;
      cs_on    <= 1'b0;
      w_q      <= 3'd1;
      left     <= '0;
      sh       <= '0;
      rx_q     <= '0;
      slots    <= '0;
      ph       <= '0;
      rx_v     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rx_v && rx_ready) rx_v <= 1'b0;
      case (st)
        S_IDLE: if (start_ok) begin
          dir_q    <= cfg_dir;
          w_q      <= w_dec;
          frag_q   <= cfg_frag;
          cs_sel_q <= cfg_cs_sel;
          left     <= start_count;
          cs_on    <= 1'b1;
          st       <= S_FETCH;
        end
        S_FETCH: begin
          if (!dir_q && tx_valid) begin
            sh    <= tx_data;
            slots <= slots_init;
            ph    <= '0;
            st    <= S_SHIFT;
          end else if (dir_q && !rx_v) begin
            sh    <= '0;
            slots <= slots_init;
            ph    <= '0;
            st    <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          ph <= ph + 2'd1;
          if (ph == 2'd2 && dir_q) sh <= sh_in;
          if (ph == 2'd3) begin
            if (slots == 4'd1) begin
              if (dir_q) begin
                rx_q <= sh;
                rx_v <= 1'b1;
              end
              left <= left - 1'b1;
              if (left == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                st     <= S_IDLE;
                done_q <= 1'b1;
                if (frag_q) cs_on <= 1'b0;
              end else begin
                st <= S_FETCH;
              end
            end else begin
              slots <= slots - 4'd1;
              if (!dir_q) sh <= sh_out;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [3:0] mask = quad ? 4'hf : dual ? 4'h3 : 4'h1;

  assign sclk     = (st == S_SHIFT) && ph[1];
  assign cs_n[0]  = !(cs_on && !cs_sel_q);
  assign cs_n[1]  = !(cs_on && cs_sel_q);
  assign lane_oe  = (!dir_q && st != S_IDLE) ? mask : 4'h0;
  assign lane_out = quad ? sh[7:4] : dual ? {2'b0, sh[7:6]} : {3'b0, sh[7]};
  assign tx_ready = (st == S_FETCH) && !dir_q;
  assign rx_data  = rx_q;
  assign rx_valid = rx_v;
  assign done     = done_q;

endmodule

// File: rtl/qspi_pio_engine_chk.sv
module qspi_pio_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic [1:0] cs_n,
  input logic [3:0] lane_oe,
  input logic       done,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic       rx_valid,
  input logic       rx_ready
);

  p_cs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_sclk_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 2'b11) |-> !sclk);

  p_sclk_high_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);

  p_sclk_low_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |=> !sclk);

  p_tx_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |-> !sclk);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_oe == 4'h0));

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> !sclk);

endmodule

bind qspi_pio_engine qspi_pio_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .lane_oe(lane_oe),
  .done(done), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/qspi_pio_engine_test.sv
module qspi_pio_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dir = 0, cfg_frag = 0, cfg_cs_sel = 0, start_wr = 0;
  logic [2:0] cfg_lanes = 3'd1;
  logic [15:0] start_count = '0;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 1, sclk, done;
  logic [1:0] cs_n;
  logic [3:0] lane_out, lane_oe, lane_in = '0;

  qspi_pio_engine uut (.*);

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // serial capture on rising sclk
  int tb_w = 1;
  logic [3:0] exp_oe = '0;
  logic [7:0] acc;
  int nb = 0, oe_bad = 0;
  logic [7:0] cap[$];
  always @(posedge sclk) begin
    for (int i = tb_w - 1; i >= 0; i--) begin
      acc = {acc[6:0], lane_out[i]};
      nb++;
      if (nb == 8) begin cap.push_back(acc); nb = 0; end
    end
    if (lane_oe != exp_oe) oe_bad++;
  end

  // read stimulus, advanced on falling sclk
  logic [7:0] src[$];
  int bitp = 0;
  bit rd_active = 0;
  task automatic set_lane_in();
    logic [3:0] v = '0;
    for (int i = 0; i < tb_w; i++) begin
      int b = bitp + i;
      logic bv = (b / 8 < src.size()) ? src[b / 8][7 - (b % 8)] : 1'b0;
      if (tb_w == 1) v[1] = bv; else v[tb_w - 1 - i] = bv;
    end
    lane_in = v;
  endtask
  always @(negedge sclk) if (rd_active) begin bitp += tb_w; set_lane_in(); end

  // sclk shape tracking
  int cyc = 0, hrun = 0;
  logic sclk_prev = 0;
  int rises[$], highs[$];
  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclk_prev) rises.push_back(cyc);
    if (sclk) hrun++;
    else if (sclk_prev) begin highs.push_back(hrun); hrun = 0; end
    sclk_prev = sclk;
  end

  function automatic logic [1:0] act_cs(input bit sel);
    return sel ? 2'b01 : 2'b10;
  endfunction

  task automatic do_start(input int cnt, input bit dir, input logic [2:0] lanes,
                          input bit frag, input bit sel);
    @(negedge clk);
    cfg_dir = dir; cfg_lanes = lanes; cfg_frag = frag; cfg_cs_sel = sel;
    start_count = 16'(cnt); start_wr = 1;
    @(negedge clk);
    start_wr = 0;
  endtask

  task automatic t_reset();
    chk(cs_n == 2'b11, "R5", "reset cs_n", cs_n, 2'b11);
    chk(!sclk, "R6", "reset sclk", sclk, 0);
    chk(lane_oe == 0, "R2", "reset oe", lane_oe, 0);
    chk(!done && !tx_ready && !rx_valid, "R8", "reset flags", {done, tx_ready, rx_valid}, 0);
  endtask

  task automatic run_write(input string tag, input logic [2:0] code, input int w,
                           input int n, input bit frag, input bit sel,
                           input int gap_at, input int gap_len, input bit poke);
    logic [7:0] d[$];
    int to, st_cyc = 0, st_bad = 0;
    bit seen = 0;
    cap.delete(); nb = 0; tb_w = w; oe_bad = 0;
    exp_oe = (w == 4) ? 4'hf : (w == 2) ? 4'h3 : 4'h1;
    for (int i = 0; i < n; i++) d.push_back(8'((i * 53 + w * 17 + 8'hA5) ^ (i << 3)));
    do_start(n, 0, code, frag, sel);
    for (int i = 0; i < n; i++) begin
      tx_data = d[i]; tx_valid = 1; to = 0;
      while (!tx_ready && to < 500) begin @(negedge clk); to++; end
      if (i == 0) chk(cs_n == act_cs(sel), "R5", {tag, " cs during"}, cs_n, act_cs(sel));
      @(negedge clk);
      tx_valid = 0;
      if (poke && i == 0) begin
        start_wr = 1; start_count = 16'd7;
        @(negedge clk);
        start_wr = 0;
      end
      if (i == gap_at) begin
        for (int k = 0; k < gap_len; k++) begin
          @(negedge clk);
          if (tx_ready) begin st_cyc++; if (sclk) st_bad++; end
        end
        chk(st_cyc > 0, "R7", {tag, " stall seen"}, st_cyc, 1);
        chk(st_bad == 0, "R7", {tag, " sclk during stall"}, st_bad, 0);
      end
    end
    to = 0;
    while (!done && to < 500) begin @(negedge clk); to++; end
    chk(done, "R8", {tag, " done seen"}, done, 1);
    chk(lane_oe == 0, "R8", {tag, " oe at done"}, lane_oe, 0);
    chk(cs_n == (frag ? 2'b11 : act_cs(sel)), "R4", {tag, " cs at done"}, cs_n,
        frag ? 2'b11 : act_cs(sel));
    @(negedge clk);
    chk(!done, "R8", {tag, " done one cycle"}, done, 0);
    repeat (4) @(negedge clk);
    chk(cap.size() == n, "R3", {tag, " byte count"}, cap.size(), n);
    for (int i = 0; i < n && i < cap.size(); i++)
      chk(cap[i] == d[i], "R3", {tag, " byte"}, cap[i], d[i]);
    chk(oe_bad == 0, "R2", {tag, " oe mask"}, oe_bad, 0);
    if (poke) begin
      bit rdy = 0;
      repeat (20) begin @(negedge clk); if (tx_ready || sclk) rdy = 1; end
      chk(!rdy, "R1", {tag, " start while busy ignored"}, rdy, 0);
    end
  endtask

  task automatic run_read(input string tag, input logic [2:0] code, input int w,
                          input int n, input bit frag, input bit sel,
                          input int hold_at, input int hold_len);
    logic [7:0] got[$];
    int to = 0, bad = 0;
    bit done_seen = 0, held = 0;
    src.delete();
    for (int i = 0; i < n; i++) src.push_back(8'((i * 91 + w * 29 + 8'h3C) ^ 8'h96));
    tb_w = w; bitp = 0; set_lane_in(); rd_active = 1; exp_oe = 0; oe_bad = 0;
    rx_ready = 1;
    do_start(n, 1, code, frag, sel);
    while (to < 2000) begin
      if (rx_valid && !held && got.size() == hold_at) begin
        logic [7:0] keep = rx_data;
        held = 1; rx_ready = 0;
        for (int k = 0; k < hold_len; k++) begin
          @(negedge clk);
          if (sclk || !rx_valid || rx_data != keep) bad++;
        end
        chk(bad == 0, "R9", {tag, " hold stalls"}, bad, 0);
        rx_ready = 1;
      end
      if (done) begin
        done_seen = 1;
        chk(rx_valid, "R8", {tag, " last byte with done"}, rx_valid, 1);
        chk(cs_n == (frag ? 2'b11 : act_cs(sel)), "R4", {tag, " cs at done"}, cs_n,
            frag ? 2'b11 : act_cs(sel));
      end
      if (rx_valid && rx_ready) got.push_back(rx_data);
      if (done_seen && got.size() >= n) break;
      @(negedge clk);
      to++;
    end
    @(negedge clk);
    rd_active = 0;
    chk(done_seen, "R8", {tag, " done seen"}, done_seen, 1);
    chk(got.size() == n, "R9", {tag, " byte count"}, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      chk(got[i] == src[i], "R3", {tag, " byte"}, got[i], src[i]);
    chk(oe_bad == 0, "R2", {tag, " oe off in read"}, oe_bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);

    rises.delete(); highs.delete();
    run_write("single", 3'd1, 1, 1, 1, 0, -1, 0, 0);
    chk(rises.size() == 8, "R6", "rise count", rises.size(), 8);
    for (int i = 1; i < rises.size(); i++)
      chk(rises[i] - rises[i-1] == 4, "R6", "rise spacing", rises[i] - rises[i-1], 4);
    for (int i = 0; i < highs.size(); i++)
      chk(highs[i] == 2, "R6", "high width", highs[i], 2);

    run_write("dual", 3'd2, 2, 4, 1, 1, 1, 40, 0);
    run_write("quad", 3'd4, 4, 5, 1, 0, -1, 0, 1);
    run_write("code3", 3'd3, 1, 2, 1, 0, -1, 0, 0);

    begin
      bit act = 0;
      do_start(0, 0, 3'd4, 1, 0);
      repeat (10) begin @(negedge clk); if (tx_ready || cs_n != 2'b11 || sclk) act = 1; end
      chk(!act, "R1", "zero count ignored", act, 0);
    end

    run_write("hold frame", 3'd4, 4, 3, 0, 0, -1, 0, 0);
    chk(cs_n == 2'b10, "R4", "cs held after frag=0", cs_n, 2'b10);
    run_read("quad rd", 3'd4, 4, 3, 1, 0, -1, 0);
    chk(cs_n == 2'b11, "R4", "cs released after frag=1", cs_n, 2'b11);
    run_read("single rd", 3'd1, 1, 3, 1, 0, 1, 30);
    run_read("dual rd", 3'd2, 2, 4, 1, 1, -1, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule